// File: doc/BRIEF.md
# Timing-Error Detection and Replay Controller

This block guards a short in-order pipeline against data that arrives too late at its stage registers. Every stage register takes its input on the rising clock edge and takes it again at the falling edge. A difference between the two copies means the input was still moving during the high phase of the clock, so the value held in the register cannot be trusted. A second source of the same fault is a replica-path input. It tracks the delay of the final stage and is read as a failure of that stage.

On a fault, recovery works like a mispredicted branch. The failing instruction and every younger one are discarded, and instructions older than the failing stage drain and commit as usual. The fetch point is reloaded with the failing instruction. One flush cycle later, issue resumes from that instruction. Any instruction leaves the pipeline only after the window of its final stage has closed clean.

A fault on an instruction whose first replay runs clean is transient, and the replay runs at full rate. If the same instruction faults again during its first replay, the fault is persistent. A slow-clock request is then raised for the second replay and dropped when that instruction commits.

Top module: `tedr_top`

## Requirements
- R1: Each stage register holding a valid instruction flags a fault when its data input changes between the rising edge that loaded it and the following falling edge. Input changes made only while the clock is low never flag a fault.
- R2: At the rising edge after a faulty window, `flushing` goes high for exactly one cycle. During that cycle `issue_valid` is low. The failing instruction and all younger ones are discarded and none of them commits.
- R3: `restart_pc` takes the instruction number of the oldest faulting stage at the same edge that raises `flushing`. At the next edge that instruction is issued (`issue_valid`=1, `issue_pc`=`restart_pc`). Issue then continues with consecutive numbers.
- R4: Instruction numbers are issued from 0 after reset and increase by one per issue, modulo 2^PCW. Commits report each instruction exactly once, in increasing order. Instructions already past the failing stage keep flowing and commit.
- R5: An instruction issued at rising edge k (seen on `issue_pc` after k) is reported on `commit_pc` with `commit_valid` after edge k+NSTG, provided none of its windows faulted.
- R6: `rep_err` high at the falling edge that closes the final stage's window, with a valid instruction in that stage, is handled as a fault of the final stage (`restart_pc` = that instruction).
- R7: A single fault on an instruction whose replay runs clean leaves `slow_req` at 0 throughout.
- R8: A second fault on the same instruction during its first replay raises `slow_req` at the edge that raises `flushing`. `slow_req` stays high until the edge at which that instruction commits, and falls at that edge.
- R9: Faults and `rep_err` in the window of the flush cycle are ignored: no further flush follows and issue resumes at `restart_pc`.
- R10: A stage that holds no valid instruction never causes a flush, whatever its data input does.
- R11: While `rst_n` is low at a rising edge, the next cycle shows `issue_valid`, `commit_valid`, `flushing` and `slow_req` all at 0.
- R12: A fault on a different instruction during a full-rate replay is treated as a new transient fault: it flushes and restarts from that instruction, and `slow_req` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the high phase is the detection window |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | NSTG*DW | Data inputs of the stage registers, stage g in bits g*DW upward |
| rep_err | input | 1 | Replica-path fault, sampled at the falling edge |
| dq | output | NSTG*DW | Main captured value of each stage register |
| issue_valid | output | 1 | Stage 0 holds an issued instruction |
| issue_pc | output | PCW | Instruction number in stage 0 |
| commit_valid | output | 1 | An instruction commits this cycle |
| commit_pc | output | PCW | Number of the committing instruction |
| flushing | output | 1 | Flush cycle in progress |
| restart_pc | output | PCW | Instruction number of the last restart point |
| slow_req | output | 1 | Reduced clock rate requested for the replay |

## Verification
Single high-phase disturbances are placed on the first, middle and last stages and on the replica input. Each of them has to yield its own restart number, which separates correct oldest-stage selection from a fixed choice of stage. The same instruction is then disturbed twice, and a pair of adjacent instructions is disturbed once each, to separate persistent from transient classification. A disturbance on an empty stage, one in the flush window, and a long run of low-phase data changes show that only real, armed windows lead to recovery. Throughout, the ordered commit stream exposes any lost, repeated or out-of-order instruction.

// File: rtl/tedr_pkg.sv
// Shared types for the timing-error detection and replay controller.
// Assumes a single clock whose high phase forms the detection window.
package tedr_pkg;
    // Pipeline flow state: running, or the single flush cycle.
    typedef enum logic {ST_RUN, ST_FLUSH} flow_e;
    // Replay classification of the most recent fault.
    typedef enum logic [1:0] {RP_NONE, RP_FAST, RP_SLOW} rpl_e;
endpackage

// File: rtl/tedr_dsreg.sv
// Double-sampling stage register. The main flop loads on the rising edge.
// A shadow flop reloads the same input on the falling edge. If the two differ
// and the window was armed (valid instruction, pipeline running), 'fault' is
// high from that falling edge until the next rising edge consumes it.
// Assumes 'chk_en' comes from rising-edge flops, so it is stable at the fall.
module tedr_dsreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q,
    output logic          fault
);
    logic [DW-1:0] shadow_q;
    logic          armed_q;

    // Main capture at the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Late capture and window arming at the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            armed_q  <= 1'b0;
        end else begin
            shadow_q <= d;
            armed_q  <= chk_en;
        end
    end

    assign fault = armed_q && (shadow_q != q);

    // An unarmed window never reports a fault.
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> !fault);
endmodule

// File: rtl/tedr_tokpipe.sv
// Instruction token pipeline: one valid bit and one instruction number per
// stage, shifting one stage per cycle. A kill request discards the tokens in
// stages 0..kill_upto as they move; older tokens move on untouched.
// Assumes NSTG >= 2.
module tedr_tokpipe #(
    parameter int NSTG = 4,
    parameter int PCW  = 8,
    parameter int SW   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_en,
    input  logic [PCW-1:0]      issue_pc,
    input  logic                kill_en,
    input  logic [SW-1:0]       kill_upto,
    output logic [NSTG-1:0]     tok_v,
    output logic [NSTG*PCW-1:0] tok_pc
);
    for (genvar g = 0; g < NSTG; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Load a newly issued instruction into stage 0.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tok_v[0]        <= 1'b0;
                    tok_pc[PCW-1:0] <= '0;
                end else begin
                    tok_v[0]        <= issue_en;
                    tok_pc[PCW-1:0] <= issue_pc;
                end
            end
        end else begin : g_body
            localparam logic [SW-1:0] PREV = SW'(g - 1);
            // Advance the token from the stage before, dropping it if killed.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tok_v[g]                <= 1'b0;
                    tok_pc[g*PCW +: PCW]    <= '0;
                end else begin
                    tok_v[g]                <= tok_v[g-1] && !(kill_en && (PREV <= kill_upto));
                    tok_pc[g*PCW +: PCW]    <= tok_pc[(g-1)*PCW +: PCW];
                end
            end
        end
    end
endmodule

// File: rtl/tedr_ctrl.sv
// Recovery controller. It picks the oldest faulting stage (the replica input
// counts as the last stage), starts a one-cycle flush, reloads the fetch point
// with the failing instruction, gates commits on a clean last-stage window and
// classifies faults as transient or persistent for the replay rate.
// Assumes fault inputs are valid at the rising edge after their window closed.
module tedr_ctrl
    import tedr_pkg::*;
#(
    parameter int NSTG = 4,
    parameter int PCW  = 8,
    parameter int SW   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSTG-1:0]     fault,
    input  logic                rep_err,
    input  logic [NSTG-1:0]     tok_v,
    input  logic [NSTG*PCW-1:0] tok_pc,
    output logic [NSTG-1:0]     chk_en,
    output logic                issue_en,
    output logic [PCW-1:0]      issue_pc,
    output logic                kill_en,
    output logic [SW-1:0]       kill_upto,
    output logic                flushing,
    output logic [PCW-1:0]      restart_pc,
    output logic                slow_req,
    output logic                commit_valid,
    output logic [PCW-1:0]      commit_pc
);
    localparam logic [SW-1:0] LAST = SW'(NSTG - 1);

    flow_e          state_q;
    rpl_e           mode_q, mode_eff;
    logic [PCW-1:0] fetch_q, rpl_pc_q, fail_pc, last_pc;
    logic [SW-1:0]  fail_stg;
    logic           rep_q, hit, commit_now, rpl_done, run;

    assign run = (state_q == ST_RUN);

    // Choose the oldest faulting stage; the replica input means the last one.
    always_comb begin
        fail_stg = '0;
        for (int i = 0; i < NSTG; i++) begin
            if (fault[i]) fail_stg = SW'(i);
        end
        if (rep_q) fail_stg = LAST;
    end

    assign hit        = run && ((|fault) || rep_q);
    assign fail_pc    = tok_pc[int'(fail_stg)*PCW +: PCW];
    assign last_pc    = tok_pc[(NSTG-1)*PCW +: PCW];
    assign chk_en     = tok_v & {NSTG{run}};
    assign issue_en   = !hit;
    assign issue_pc   = fetch_q;
    assign kill_en    = hit;
    assign kill_upto  = fail_stg;
    assign commit_now = tok_v[NSTG-1] && !(hit && (fail_stg == LAST));
    assign rpl_done   = commit_now && (mode_q != RP_NONE) && (last_pc == rpl_pc_q);
    assign mode_eff   = rpl_done ? RP_NONE : mode_q;
    assign flushing   = (state_q == ST_FLUSH);
    assign slow_req   = (mode_q == RP_SLOW);

    // Sample the replica fault at the end of the final stage's window.
    always_ff @(negedge clk) begin
        if (!rst_n) rep_q <= 1'b0;
        else        rep_q <= rep_err && chk_en[NSTG-1];
    end

    // Fetch point, flow state, restart point and commit report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_RUN;
            fetch_q      <= '0;
            restart_pc   <= '0;
            commit_valid <= 1'b0;
            commit_pc    <= '0;
        end else begin
            state_q      <= hit ? ST_FLUSH : ST_RUN;
            fetch_q      <= hit ? fail_pc : fetch_q + PCW'(1);
            if (hit) restart_pc <= fail_pc;
            commit_valid <= commit_now;
            commit_pc    <= last_pc;
        end
    end

    // Transient / persistent classification and replay-rate selection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= RP_NONE;
            rpl_pc_q <= '0;
        end else if (hit) begin
            case (mode_eff)
                RP_NONE: begin
                    mode_q   <= RP_FAST;
                    rpl_pc_q <= fail_pc;
                end
                RP_FAST: begin
                    if (fail_pc == rpl_pc_q) begin
                        mode_q <= RP_SLOW;
                    end else begin
                        mode_q   <= RP_FAST;
                        rpl_pc_q <= fail_pc;
                    end
                end
                default: mode_q <= RP_SLOW;
            endcase
        end else begin
            mode_q <= mode_eff;
        end
    end
endmodule

// File: rtl/tedr_top.sv
// Timing-error detection and replay controller, top level. It wraps NSTG
// double-sampling stage registers, the instruction token pipeline and the
// recovery controller. Issue is continuous; recovery is the only stall.
// Assumes NSTG >= 2 and a stable clock whose high phase is the window.
module tedr_top #(
    parameter int NSTG = 4,
    parameter int DW   = 8,
    parameter int PCW  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSTG*DW-1:0]  din,
    input  logic                rep_err,
    output logic [NSTG*DW-1:0]  dq,
    output logic                issue_valid,
    output logic [PCW-1:0]      issue_pc,
    output logic                commit_valid,
    output logic [PCW-1:0]      commit_pc,
    output logic                flushing,
    output logic [PCW-1:0]      restart_pc,
    output logic                slow_req
);
    localparam int SW = (NSTG > 1) ? $clog2(NSTG) : 1;

    logic [NSTG-1:0]     fault, chk_en, tok_v;
    logic [NSTG*PCW-1:0] tok_pc;
    logic                issue_en, kill_en;
    logic [PCW-1:0]      fetch_pc;
    logic [SW-1:0]       kill_upto;

    for (genvar g = 0; g < NSTG; g++) begin : g_reg
        tedr_dsreg #(.DW(DW)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .chk_en (chk_en[g]),
            .d      (din[g*DW +: DW]),
            .q      (dq[g*DW +: DW]),
            .fault  (fault[g])
        );
    end

    tedr_tokpipe #(.NSTG(NSTG), .PCW(PCW), .SW(SW)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_en  (issue_en),
        .issue_pc  (fetch_pc),
        .kill_en   (kill_en),
        .kill_upto (kill_upto),
        .tok_v     (tok_v),
        .tok_pc    (tok_pc)
    );

    tedr_ctrl #(.NSTG(NSTG), .PCW(PCW), .SW(SW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fault        (fault),
        .rep_err      (rep_err),
        .tok_v        (tok_v),
        .tok_pc       (tok_pc),
        .chk_en       (chk_en),
        .issue_en     (issue_en),
        .issue_pc     (fetch_pc),
        .kill_en      (kill_en),
        .kill_upto    (kill_upto),
        .flushing     (flushing),
        .restart_pc   (restart_pc),
        .slow_req     (slow_req),
        .commit_valid (commit_valid),
        .commit_pc    (commit_pc)
    );

    assign issue_valid = tok_v[0];
    assign issue_pc    = tok_pc[PCW-1:0];

    // The flush cycle is a bubble at the head of the pipeline.
    assert_flush_bubble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |-> !issue_valid);

    // The instruction issued right after the flush is the restart point.
    assert_restart_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flushing |=> (issue_valid && (issue_pc == restart_pc)));

    // Back-to-back commits are consecutive instruction numbers.
    assert_commit_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && $past(commit_valid)) |-> (commit_pc == $past(commit_pc) + PCW'(1)));

    // The reduced rate is released only together with a commit.
    assert_slow_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(slow_req) |-> commit_valid);
endmodule

// File: tb/tb_tedr_top.sv
module tb_tedr_top;
    localparam int NSTG = 4;
    localparam int DW   = 8;
    localparam int PCW  = 8;
    localparam int NV   = 6;
    // Fault site per vector: stage index, or NSTG for the replica input.
    localparam int VKIND [NV] = '{0, 2, 3, NSTG, 1, 3};

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NSTG*DW-1:0]  din = '0;
    logic                rep_err = 1'b0;
    logic [NSTG*DW-1:0]  dq;
    logic                issue_valid, commit_valid, flushing, slow_req;
    logic [PCW-1:0]      issue_pc, commit_pc, restart_pc;

    int total = 0, bad = 0, cyc = 0, ncommit = 0, first_commit_cyc = -1;
    logic [PCW-1:0] exp_pc = '0;

    tedr_top #(.NSTG(NSTG), .DW(DW), .PCW(PCW)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .rep_err(rep_err), .dq(dq),
        .issue_valid(issue_valid), .issue_pc(issue_pc),
        .commit_valid(commit_valid), .commit_pc(commit_pc),
        .flushing(flushing), .restart_pc(restart_pc), .slow_req(slow_req)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic next_low();
        @(negedge clk); #3;
    endtask

    task automatic to_high();
        @(posedge clk); #2;
    endtask

    task automatic flip(input int s);
        din[s*DW +: DW] = ~din[s*DW +: DW];
    endtask

    // Data inputs change only in the low phase unless a test disturbs them.
    always @(negedge clk) begin
        #1;
        cyc++;
        for (int s = 0; s < NSTG; s++) din[s*DW +: DW] = DW'(cyc * 3 + s * 17);
    end

    // R4: every commit must be the next instruction number, exactly once.
    always @(negedge clk) begin
        #3;
        if (rst_n && commit_valid) begin
            chk(commit_pc == exp_pc, "R4 commit order", commit_pc, exp_pc);
            if (first_commit_cyc < 0) first_commit_cyc = cyc;
            exp_pc++;
            ncommit++;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [PCW-1:0] p, q;
        int c0, nflush, k;
        bit seen, held;

        // R11: reset state.
        repeat (3) @(posedge clk);
        next_low();
        chk(!issue_valid, "R11 issue_valid in reset", issue_valid, 0);
        chk(!commit_valid, "R11 commit_valid in reset", commit_valid, 0);
        chk(!flushing, "R11 flushing in reset", flushing, 0);
        chk(!slow_req, "R11 slow_req in reset", slow_req, 0);
        rst_n = 1'b1;

        next_low();
        chk(issue_valid && issue_pc == 0, "R4 first issue", issue_pc, 0);
        c0 = cyc;
        // R10: disturb the empty last stage.
        to_high();
        flip(NSTG - 1);
        next_low();
        next_low();
        chk(!flushing, "R10 empty stage ignored", flushing, 0);
        for (int i = 0; i < 10 && first_commit_cyc < 0; i++) next_low();
        chk(first_commit_cyc - c0 == NSTG, "R5 commit latency", first_commit_cyc - c0, NSTG);

        // R1: low-phase changes never flag.
        nflush = 0;
        for (int i = 0; i < 20; i++) begin
            next_low();
            if (flushing) nflush++;
        end
        chk(nflush == 0, "R1 low-phase changes", nflush, 0);

        // Vector table: single disturbances at several sites (R1 R2 R3 R6 R7).
        for (int v = 0; v < NV; v++) begin
            repeat (8) next_low();
            to_high();
            q = issue_pc;
            k = VKIND[v];
            if (k == NSTG) begin
                rep_err = 1'b1;
                p = q - PCW'(NSTG - 1);
            end else begin
                flip(k);
                p = q - PCW'(k);
            end
            next_low();
            rep_err = 1'b0;
            next_low();
            chk(flushing, "R1 R2 window fault flushes", flushing, 1);
            chk(restart_pc == p, (k == NSTG) ? "R6 replica restart" : "R3 restart point",
                restart_pc, p);
            next_low();
            chk(!flushing, "R2 flush lasts one cycle", flushing, 0);
            chk(issue_valid && issue_pc == p, "R3 reissue", issue_pc, p);
            repeat (6) next_low();
            chk(!slow_req, "R7 transient stays full rate", slow_req, 0);
        end

        // R9: a disturbance in the flush window is ignored.
        repeat (8) next_low();
        to_high();
        p = issue_pc;
        flip(0);
        next_low();
        to_high();
        flip(2);
        next_low();
        chk(flushing && restart_pc == p, "R9 first flush", restart_pc, p);
        next_low();
        chk(!flushing && issue_pc == p, "R9 resume at restart", issue_pc, p);
        next_low();
        chk(!flushing, "R9 no second flush", flushing, 0);

        // R8: same instruction fails again on its first replay.
        repeat (8) next_low();
        to_high();
        p = issue_pc;
        flip(0);
        next_low();
        next_low();
        chk(!slow_req, "R7 first fault full rate", slow_req, 0);
        to_high();
        chk(issue_pc == p, "R8 replay issued", issue_pc, p);
        flip(0);
        next_low();
        next_low();
        chk(flushing && slow_req, "R8 persistent raises slow_req", slow_req, 1);
        seen = 0;
        held = 1;
        for (int i = 0; i < 12 && !seen; i++) begin
            next_low();
            if (commit_valid && commit_pc == p) begin
                seen = 1;
                chk(!slow_req, "R8 release at commit", slow_req, 0);
            end else if (!slow_req) begin
                held = 0;
            end
        end
        chk(seen, "R8 replayed instruction commits", seen, 1);
        chk(held, "R8 slow_req held until commit", held, 1);

        // R12: a different instruction fails during a full-rate replay.
        repeat (8) next_low();
        to_high();
        p = issue_pc;
        flip(0);
        next_low();
        next_low();
        to_high();
        chk(issue_pc == p, "R12 replay issued", issue_pc, p);
        next_low();
        to_high();
        chk(issue_pc == p + 1, "R12 next instruction", issue_pc, p + 1);
        flip(0);
        next_low();
        next_low();
        chk(flushing && restart_pc == p + 1, "R12 restart at new instruction", restart_pc, p + 1);
        chk(!slow_req, "R12 no slow request", slow_req, 0);
        repeat (8) next_low();
        chk(!slow_req, "R12 still full rate", slow_req, 0);

        repeat (10) next_low();
        chk(ncommit > 50, "R4 commits keep flowing", ncommit, 51);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule